// File: doc/BRIEF.md
# Ethernet Inter-Packet Gap Timer

This block sits in the transmit path of an Ethernet MAC and holds transmission off for the idle gap that must separate two frames. Once a frame has finished, the block stretches a quiet period whose length depends on three things: the link mode (half or full duplex), whether the next frame follows directly on the previous one, and whether the next frame is a retransmission. A single output, `tx_allow`, tells the transmitter when it may start. Time is counted in MAC clock cycles.

A 32-bit gap register holds three 10-bit lengths. The first is the back-to-back gap. The second is the carrier-sensitive window used in half duplex. The third is the total deferral gap used in half duplex. A fixed offset of six clocks is added to the back-to-back gap and to the total deferral gap. A separate 16-bit throttle value can stretch the back-to-back gap of initial transmissions: the block uses the larger of the two lengths. In half duplex, when the next frame is not back-to-back, carrier activity early in the gap starts the count again. Carrier activity later in the gap is ignored.

All gap parameters are captured when a gap starts. A register write made during a gap therefore only affects the gaps that follow it.

Top module: `ifg_gap_timer`

## Requirements
- R1: After reset, the gap register and the throttle value read as zero, and `tx_allow` is high from the first cycle after reset is released.
- R2: In the gap register, bits 9:0 hold the back-to-back gap G, bits 19:10 hold the carrier window W, and bits 29:20 hold the deferral gap D. Bits 31:30 always read as zero, whatever value was written to them.
- R3: A `frame_done` pulse sampled at a clock edge drops `tx_allow` from that edge onward. In back-to-back mode, `tx_allow` stays low for exactly G+6 cycles and then returns high.
- R4: In half duplex with `next_back2back`=0 and no carrier, `tx_allow` stays low for exactly D+6 cycles.
- R5: In that deferral mode, carrier sampled high at an edge where fewer than W cycles of the gap have elapsed restarts the count. `tx_allow` then rises D+6 cycles after that edge.
- R6: In that deferral mode, carrier sampled at an edge where W or more cycles have elapsed has no effect on the gap length.
- R7: In full duplex, the back-to-back rule is used whatever the value of `next_back2back`, and carrier has no effect on the gap.
- R8: For an initial transmission (`next_is_retry`=0) under the back-to-back rule, the gap lasts max(G+6, T) cycles, where T is the throttle value.
- R9: For a retransmission (`next_is_retry`=1), the throttle value is ignored and the gap is G+6 cycles.
- R10: A register write made while a gap is running does not change that gap. The new value applies from the next `frame_done` onward.
- R11: A `frame_done` pulse that arrives during a gap starts a fresh gap from that edge.
- R12: While no gap is pending, `tx_allow` stays high, and carrier activity has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gap_cfg_we | input | 1 | Write strobe for the gap register |
| gap_cfg_wdata | input | 32 | Gap register write data |
| gap_cfg_rdata | output | 32 | Gap register contents (reserved bits read as zero) |
| thr_we | input | 1 | Write strobe for the throttle value |
| thr_wdata | input | 16 | Throttle value, in MAC clocks |
| frame_done | input | 1 | One-cycle pulse marking the end of a transmitted frame |
| next_back2back | input | 1 | Next frame follows back-to-back; sampled with `frame_done` |
| next_is_retry | input | 1 | Next frame is a retransmission; sampled with `frame_done` |
| carrier | input | 1 | Carrier sense from the medium |
| half_dup | input | 1 | 1 = half duplex, 0 = full duplex; sampled with `frame_done` |
| tx_allow | output | 1 | High when the gap is satisfied and transmission may start |

## Verification
The hardest case to reach from the ports is carrier activity that lands on the exact cycle where the elapsed count meets the carrier window W. The stimulus covers this by sweeping W and D over small values. For each pair it replays the gap once per possible carrier position, pulsing carrier for a single cycle at a known edge offset after `frame_done`. This puts the pulse on both sides of W and exactly on it. Writes and a second `frame_done` are also placed at fixed offsets inside a running gap, to show that the parameters were captured at the start of the gap.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

    // Kind of gap currently being timed
    typedef enum logic [1:0] {
        GAP_NONE  = 2'd0,
        GAP_PLAIN = 2'd1,
        GAP_DEFER = 2'd2
    } gap_kind_t;

    localparam int IFG_FIELD_W_DEF = 10;
    localparam int IFG_THR_W_DEF   = 16;
    localparam int IFG_REG_W_DEF   = 32;
    localparam int IFG_OFS_DEF     = 6;

endpackage

// File: rtl/ifg_cfg_regs.sv
module ifg_cfg_regs #(
    parameter int REG_W = 32,
    parameter int FLD_W = 10,
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic [FLD_W-1:0] f_gap,
    output logic [FLD_W-1:0] f_win,
    output logic [FLD_W-1:0] f_def,
    output logic [THR_W-1:0] thr_val
);
    localparam int USED_W = 3 * FLD_W;
    localparam logic [REG_W-1:0] FIELD_MASK = REG_W'({USED_W{1'b1}});

    typedef struct packed {
        logic [REG_W-1:0] raw;
        logic [THR_W-1:0] thr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            regs_d.raw = cfg_wdata & FIELD_MASK;
        end
        if (thr_we) begin
            regs_d.thr = thr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg_rdata = regs_q.raw;
    assign f_gap     = regs_q.raw[FLD_W-1:0];
    assign f_win     = regs_q.raw[2*FLD_W-1:FLD_W];
    assign f_def     = regs_q.raw[3*FLD_W-1:2*FLD_W];
    assign thr_val   = regs_q.thr;

endmodule

// File: rtl/ifg_gap_select.sv
module ifg_gap_select #(
    parameter int FLD_W = 10,
    parameter int THR_W = 16,
    parameter int CNT_W = 17,
    parameter int OFS   = 6
) (
    input  logic [FLD_W-1:0] f_gap,
    input  logic [FLD_W-1:0] f_win,
    input  logic [FLD_W-1:0] f_def,
    input  logic [THR_W-1:0] thr_val,
    input  logic             half_dup,
    input  logic             back2back,
    input  logic             is_retry,
    output logic [CNT_W-1:0] sel_len,
    output logic [FLD_W-1:0] sel_win,
    output logic             sel_defer
);
    logic [CNT_W-1:0] len_b2b;
    logic [CNT_W-1:0] len_def;
    logic [CNT_W-1:0] len_thr;

    always_comb begin
        len_b2b = CNT_W'(f_gap) + CNT_W'(OFS);
        len_def = CNT_W'(f_def) + CNT_W'(OFS);
        len_thr = CNT_W'(thr_val);
        if (half_dup && !back2back) begin
            sel_defer = 1'b1;
            sel_len   = len_def;
            sel_win   = f_win;
        end else begin
            sel_defer = 1'b0;
            sel_win   = '0;
            if (!is_retry && (len_thr > len_b2b)) begin
                sel_len = len_thr;
            end else begin
                sel_len = len_b2b;
            end
        end
    end

endmodule

// File: rtl/ifg_gap_counter.sv
module ifg_gap_counter
    import ifg_pkg::*;
#(
    parameter int FLD_W = 10,
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] sel_len,
    input  logic [FLD_W-1:0] sel_win,
    input  logic             sel_defer,
    input  logic             carrier,
    output logic             busy
);
    typedef struct packed {
        gap_kind_t        kind;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic [FLD_W-1:0] win;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             in_window;

    always_comb begin
        st_d      = st_q;
        cnt_inc   = st_q.cnt + CNT_W'(1);
        in_window = (st_q.cnt < CNT_W'(st_q.win));
        if (start) begin
            st_d.kind = sel_defer ? GAP_DEFER : GAP_PLAIN;
            st_d.cnt  = '0;
            st_d.len  = sel_len;
            st_d.win  = sel_win;
        end else if ((st_q.kind == GAP_DEFER) && carrier && in_window) begin
            st_d.cnt = '0;
        end else if (st_q.kind != GAP_NONE) begin
            if (cnt_inc == st_q.len) begin
                st_d.kind = GAP_NONE;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.kind <= GAP_NONE;
            st_q.cnt  <= '0;
            st_q.len  <= '0;
            st_q.win  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.kind != GAP_NONE);

endmodule

// File: rtl/ifg_gap_timer.sv
module ifg_gap_timer #(
    parameter int REG_W = ifg_pkg::IFG_REG_W_DEF,
    parameter int FLD_W = ifg_pkg::IFG_FIELD_W_DEF,
    parameter int THR_W = ifg_pkg::IFG_THR_W_DEF,
    parameter int OFS   = ifg_pkg::IFG_OFS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gap_cfg_we,
    input  logic [REG_W-1:0] gap_cfg_wdata,
    output logic [REG_W-1:0] gap_cfg_rdata,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             frame_done,
    input  logic             next_back2back,
    input  logic             next_is_retry,
    input  logic             carrier,
    input  logic             half_dup,
    output logic             tx_allow
);
    localparam int WIDE_W = (THR_W > FLD_W + 1) ? THR_W : FLD_W + 1;
    localparam int CNT_W  = WIDE_W + 1;

    logic [FLD_W-1:0] f_gap, f_win, f_def, sel_win;
    logic [THR_W-1:0] thr_val;
    logic [CNT_W-1:0] sel_len;
    logic             sel_defer;
    logic             busy;

    ifg_cfg_regs #(
        .REG_W(REG_W), .FLD_W(FLD_W), .THR_W(THR_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (gap_cfg_we),
        .cfg_wdata (gap_cfg_wdata),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .cfg_rdata (gap_cfg_rdata),
        .f_gap     (f_gap),
        .f_win     (f_win),
        .f_def     (f_def),
        .thr_val   (thr_val)
    );

    ifg_gap_select #(
        .FLD_W(FLD_W), .THR_W(THR_W), .CNT_W(CNT_W), .OFS(OFS)
    ) i_sel (
        .f_gap     (f_gap),
        .f_win     (f_win),
        .f_def     (f_def),
        .thr_val   (thr_val),
        .half_dup  (half_dup),
        .back2back (next_back2back),
        .is_retry  (next_is_retry),
        .sel_len   (sel_len),
        .sel_win   (sel_win),
        .sel_defer (sel_defer)
    );

    ifg_gap_counter #(
        .FLD_W(FLD_W), .CNT_W(CNT_W)
    ) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (frame_done),
        .sel_len   (sel_len),
        .sel_win   (sel_win),
        .sel_defer (sel_defer),
        .carrier   (carrier),
        .busy      (busy)
    );

    assign tx_allow = !busy;

endmodule

// File: rtl/ifg_gap_timer_chk.sv
module ifg_gap_timer_chk #(
    parameter int REG_W = 32,
    parameter int OFS   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_done,
    input logic             tx_allow,
    input logic             gap_cfg_we,
    input logic [REG_W-1:0] gap_cfg_rdata
);
    // Cycles since the last frame_done, saturating
    logic [7:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (frame_done) begin
            since_q <= '0;
        end else if (since_q != 8'hFF) begin
            since_q <= since_q + 8'd1;
        end
    end

    assert_gap_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !tx_allow);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_allow && !frame_done) |=> tx_allow);

    assert_min_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_allow) |-> (since_q >= 8'(OFS)));

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !gap_cfg_we |=> $stable(gap_cfg_rdata));

endmodule

bind ifg_gap_timer ifg_gap_timer_chk #(.REG_W(REG_W), .OFS(OFS)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_done    (frame_done),
    .tx_allow      (tx_allow),
    .gap_cfg_we    (gap_cfg_we),
    .gap_cfg_rdata (gap_cfg_rdata)
);

// File: tb/test_ifg_gap_timer.sv
`timescale 1ns/1ps
module test_ifg_gap_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gap_cfg_we = 1'b0;
    logic [31:0] gap_cfg_wdata = '0;
    logic [31:0] gap_cfg_rdata;
    logic        thr_we = 1'b0;
    logic [15:0] thr_wdata = '0;
    logic        frame_done = 1'b0;
    logic        next_back2back = 1'b0;
    logic        next_is_retry = 1'b0;
    logic        carrier = 1'b0;
    logic        half_dup = 1'b0;
    logic        tx_allow;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ifg_gap_timer i_ifg_gap_timer (
        .clk(clk), .rst_n(rst_n),
        .gap_cfg_we(gap_cfg_we), .gap_cfg_wdata(gap_cfg_wdata), .gap_cfg_rdata(gap_cfg_rdata),
        .thr_we(thr_we), .thr_wdata(thr_wdata),
        .frame_done(frame_done), .next_back2back(next_back2back), .next_is_retry(next_is_retry),
        .carrier(carrier), .half_dup(half_dup), .tx_allow(tx_allow)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack(input int g, input int w, input int d);
        return (32'(d) << 20) | (32'(w) << 10) | 32'(g);
    endfunction

    task automatic wr_cfg(input logic [31:0] v);
        @(negedge clk);
        gap_cfg_we = 1'b1;
        gap_cfg_wdata = v;
        @(negedge clk);
        gap_cfg_we = 1'b0;
    endtask

    task automatic wr_thr(input int v);
        @(negedge clk);
        thr_we = 1'b1;
        thr_wdata = 16'(v);
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    // Pulse frame_done, then count low cycles of tx_allow.
    // Stimulus offsets: index i is applied at the i-th negedge after the start edge.
    task automatic run_gap(input int fe_at, input int crs_at, input int wr_at,
                           input logic [31:0] wr_val, output int low);
        @(negedge clk);
        frame_done = 1'b1;
        @(posedge clk);
        low = 0;
        for (int i = 1; i < 70000; i++) begin
            @(negedge clk);
            if (tx_allow) break;
            low++;
            frame_done = (i == fe_at);
            carrier    = (i == crs_at);
            gap_cfg_we = (i == wr_at);
            gap_cfg_wdata = wr_val;
        end
        frame_done = 1'b0;
        carrier    = 1'b0;
        gap_cfg_we = 1'b0;
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int low;
        int exp;
        int len;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx_allow after reset", tx_allow, 1);
        chk("R1 gap register after reset", gap_cfg_rdata, 0);
        run_gap(0, 0, 0, 0, low);
        chk("R1 throttle zero after reset (gap=6)", low, 6);

        // R12: idle with carrier activity
        half_dup = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            carrier = (c % 2 == 0);
            chk("R12 idle tx_allow stays high", tx_allow, 1);
        end
        carrier = 1'b0;

        // R2: layout and reserved bits
        wr_cfg(32'hFFFF_FFFF);
        chk("R2 reserved bits read zero", gap_cfg_rdata, 32'h3FFF_FFFF);
        wr_cfg(32'h0060_2006);
        chk("R2 readback", gap_cfg_rdata, 32'h0060_2006);
        half_dup = 1'b1; next_back2back = 1'b1;
        run_gap(0, 0, 0, 0, low);
        chk("R2 R3 back-to-back field gives 12", low, 12);
        next_back2back = 1'b0;
        run_gap(0, 0, 0, 0, low);
        chk("R2 R4 deferral field gives 12", low, 12);

        // Full duplex sweep: R3 R7 R8 R9
        half_dup = 1'b0;
        for (int g = 0; g < 6; g++) begin
            wr_cfg(pack(g, 3, 1));
            for (int ti = 0; ti < 5; ti++) begin
                wr_thr(ti * 3 + (ti == 4 ? 2 : 0));
                for (int r = 0; r < 2; r++) begin
                    for (int b = 0; b < 2; b++) begin
                        next_is_retry  = r[0];
                        next_back2back = b[0];
                        run_gap(0, 2, 0, 0, low);
                        len = ti * 3 + (ti == 4 ? 2 : 0);
                        exp = (r == 0 && len > g + 6) ? len : g + 6;
                        chk(r == 0 ? "R8 R7 full duplex initial gap" : "R9 R7 full duplex retry gap",
                            low, exp);
                    end
                end
            end
        end

        // Large throttle
        wr_cfg(pack(0, 0, 0));
        wr_thr(300);
        next_is_retry = 1'b0;
        run_gap(0, 0, 0, 0, low);
        chk("R8 large throttle", low, 300);
        next_is_retry = 1'b1;
        run_gap(0, 0, 0, 0, low);
        chk("R9 retry ignores large throttle", low, 6);
        wr_thr(0);
        next_is_retry = 1'b0;

        // Half duplex back-to-back ignores carrier: R3
        half_dup = 1'b1; next_back2back = 1'b1;
        for (int g = 0; g < 4; g++) begin
            wr_cfg(pack(g, 5, 2));
            run_gap(0, 1, 0, 0, low);
            chk("R3 half duplex back-to-back gap", low, g + 6);
        end

        // Half duplex deferral sweep: R4 R5 R6
        next_back2back = 1'b0;
        for (int w = 0; w < 4; w++) begin
            for (int d = 0; d < 4; d++) begin
                wr_cfg(pack(1, w, d));
                run_gap(0, 0, 0, 0, low);
                chk("R4 deferral gap without carrier", low, d + 6);
                for (int k = 1; k <= d + 6; k++) begin
                    run_gap(0, k, 0, 0, low);
                    if (k - 1 < w) begin
                        chk("R5 carrier inside window restarts", low, k + d + 6);
                    end else begin
                        chk("R6 carrier after window ignored", low, d + 6);
                    end
                end
            end
        end

        // R10: write during a gap
        half_dup = 1'b0;
        wr_cfg(pack(2, 0, 0));
        run_gap(0, 0, 3, pack(9, 0, 0), low);
        chk("R10 running gap unaffected by write", low, 8);
        chk("R10 written value visible", gap_cfg_rdata, pack(9, 0, 0));
        run_gap(0, 0, 0, 0, low);
        chk("R10 next gap uses new value", low, 15);

        // R11: frame_done during a gap
        wr_cfg(pack(4, 0, 0));
        run_gap(3, 0, 0, 0, low);
        chk("R11 restart by frame_done", low, 13);
        @(negedge clk);
        chk("R12 high after gap", tx_allow, 1);

        summary();
        $finish;
    end
endmodule